// File: doc/BRIEF.md
# Slow-Tick Real-Time Counter with Compare Channels

This block is a low-rate real-time counter for always-on timekeeping. A programmable divider turns every `prescale + 1` cycles of the slow input clock into one counter tick. Single-cycle strobes start, halt or zero the counter. Its value can be read at any time.

Four compare channels each watch for the counter reaching a programmed value. A wrap of the counter at full width raises an overflow event. Events are latched into sticky flags, and any enabled flag drives one level interrupt.

Any compare channel can also be routed to zero the counter in hardware, so the count wraps at a custom top value without software help. Compare behaviour follows a slow-clock timer closely:
- a compare value only takes effect at a tick boundary, so a value one ahead of the count is missed;
- zeroing the counter never counts as reaching a compare value of zero.

Top module: `slowtick_rtc`

## Requirements
- R1: After reset the counter reads zero and is halted. All event flags are clear and `irq` is low.
- R2: While running, the counter advances by one every `prescale + 1` cycles. After a combined clear-and-start strobe, the count after k cycles is floor(k / (prescale + 1)).
- R3: A start strobe makes the counter run and a stop strobe halts it. A halted counter holds its value. When start and stop arrive in the same cycle, stop wins.
- R4: A clear strobe zeroes the counter and restarts the divider phase. It takes priority over a tick in the same cycle and does not change the run state.
- R5: A tick from all ones to zero sets the overflow flag, `evt_flags` bit 4 (the bit index equals the channel count).
- R6: Compare channel i sets `evt_flags` bit i when a tick brings the counter to equal that channel's active compare value.
- R7: A compare write goes to a holding register and becomes active at the next tick. A value equal to the current count plus one therefore produces no event on that tick.
- R8: Zeroing the counter by a clear strobe, or by a routed wrap, never raises a compare event, even for a compare value of zero.
- R9: An event is recorded only when its `evt_en` bit is set. A flag stays set until its `evt_clr` bit is strobed, and the strobe leaves the other flags untouched.
- R10: `irq` is high exactly when some flag is set and its `int_en` bit is set.
- R11: When channel i has its `wrap_route` bit set and raises a match at value v, the next tick takes the counter to zero instead of v+1. The period is then v+1 ticks and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow input clock |
| rst | input | 1 | Synchronous active-high reset |
| task_start | input | 1 | Start strobe |
| task_stop | input | 1 | Stop strobe |
| task_clear | input | 1 | Clear strobe, zeroes the counter |
| prescale | input | PRESC_W | Divide ratio minus one |
| cmp_wr | input | NCH | Per-channel compare write strobes |
| cmp_wdata | input | CNT_W | Compare value to write |
| evt_en | input | NCH+1 | Event record enables (bit NCH is overflow) |
| int_en | input | NCH+1 | Interrupt enables per flag |
| evt_clr | input | NCH+1 | Flag clear strobes |
| wrap_route | input | NCH | Per-channel compare-to-clear routes |
| counter_value | output | CNT_W | Current count |
| evt_flags | output | NCH+1 | Sticky event flags |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the properties that hold on every cycle:
- the count only steps by one or drops to zero;
- the count holds while halted;
- a clear strobe yields zero and raises no new flag;
- the overflow flag rises only on an all-ones to zero step;
- flags fall only under their clear strobe.

The timing-dependent behaviours can only be shown by the bench scenarios:
- the exact tick spacing for each divide ratio;
- the compare value that becomes active too late and is missed;
- the custom wrap period under a route;
- the event-enable and interrupt-enable gating.

These are checked against arithmetic on a narrow counter.

// File: rtl/slowtick_rtc_pkg.sv
package slowtick_rtc_pkg;

    localparam int unsigned PRESC_W_DEF = 12;
    localparam int unsigned CNT_W_DEF   = 24;
    localparam int unsigned NCH_DEF     = 4;

    typedef struct packed {
        logic start;
        logic stop;
        logic clear;
    } rtc_task_t;

    typedef enum logic {
        RTC_HALT = 1'b0,
        RTC_RUN  = 1'b1
    } rtc_run_e;

    // Stop dominates start; clear does not touch the run state.
    function automatic rtc_run_e rtc_run_next(rtc_run_e cur, rtc_task_t t);
        rtc_run_e nxt;
        nxt = cur;
        if (t.stop)
            nxt = RTC_HALT;
        else if (t.start)
            nxt = RTC_RUN;
        return nxt;
    endfunction

endpackage

// File: rtl/slowtick_rtc_divider.sv
module slowtick_rtc_divider #(
    parameter int unsigned PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          restart,
    input  logic [PW-1:0] ratio,
    output logic          tick
);
    logic [PW-1:0] phase_q;
    logic          at_end;

    assign at_end = (phase_q >= ratio);
    assign tick   = run & ~restart & at_end;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (restart)
            phase_q <= '0;
        else if (run)
            phase_q <= at_end ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/slowtick_rtc_counter.sv
module slowtick_rtc_counter #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    input  logic         wrap_req,
    output logic [W-1:0] count,
    output logic [W-1:0] next_count,
    output logic         advance,
    output logic         rollover
);
    logic [W-1:0] count_q;

    assign count      = count_q;
    assign next_count = count_q + 1'b1;
    assign advance    = tick & ~clear & ~wrap_req;
    assign rollover   = advance & (&count_q);

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (clear)
            count_q <= '0;
        else if (tick)
            count_q <= wrap_req ? '0 : next_count;
    end
endmodule

// File: rtl/slowtick_rtc_channel.sv
module slowtick_rtc_channel #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         boundary,
    input  logic         advance,
    input  logic [W-1:0] next_count,
    output logic         hit
);
    logic [W-1:0] hold_q;
    logic [W-1:0] active_q;

    // The match uses the value active before this boundary.
    assign hit = advance & (next_count == active_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            active_q <= '0;
        end else begin
            if (wr)
                hold_q <= wdata;
            if (boundary)
                active_q <= hold_q;
        end
    end
endmodule

// File: rtl/slowtick_rtc.sv
module slowtick_rtc
    import slowtick_rtc_pkg::*;
#(
    parameter int unsigned CNT_W   = CNT_W_DEF,
    parameter int unsigned NCH     = NCH_DEF,
    parameter int unsigned PRESC_W = PRESC_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               task_start,
    input  logic               task_stop,
    input  logic               task_clear,
    input  logic [PRESC_W-1:0] prescale,
    input  logic [NCH-1:0]     cmp_wr,
    input  logic [CNT_W-1:0]   cmp_wdata,
    input  logic [NCH:0]       evt_en,
    input  logic [NCH:0]       int_en,
    input  logic [NCH:0]       evt_clr,
    input  logic [NCH-1:0]     wrap_route,
    output logic [CNT_W-1:0]   counter_value,
    output logic [NCH:0]       evt_flags,
    output logic               irq
);
    localparam int unsigned NEV = NCH + 1;

    rtc_task_t        tsk;
    rtc_run_e         run_q;
    logic             is_running;
    logic             tick;
    logic             advance;
    logic             rollover;
    logic             route_pend_q;
    logic [CNT_W-1:0] next_count;
    logic [NCH-1:0]   hit;
    logic [NEV-1:0]   raw_evt;
    logic [NEV-1:0]   flags_q;

    assign tsk        = '{start: task_start, stop: task_stop, clear: task_clear};
    assign is_running = (run_q == RTC_RUN);

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= RTC_HALT;
        else
            run_q <= rtc_run_next(run_q, tsk);
    end

    slowtick_rtc_divider #(.PW(PRESC_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (is_running),
        .restart (tsk.clear),
        .ratio   (prescale),
        .tick    (tick)
    );

    slowtick_rtc_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .clear      (tsk.clear),
        .wrap_req   (route_pend_q),
        .count      (counter_value),
        .next_count (next_count),
        .advance    (advance),
        .rollover   (rollover)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        slowtick_rtc_channel #(.W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .wr         (cmp_wr[i]),
            .wdata      (cmp_wdata),
            .boundary   (tick),
            .advance    (advance),
            .next_count (next_count),
            .hit        (hit[i])
        );
    end

    // A routed match asks the following tick to wrap to zero.
    always_ff @(posedge clk) begin
        if (rst)
            route_pend_q <= 1'b0;
        else if (tsk.clear)
            route_pend_q <= 1'b0;
        else if (tick)
            route_pend_q <= |(hit & wrap_route);
    end

    assign raw_evt = {rollover, hit};

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~evt_clr) | (raw_evt & evt_en);
    end

    assign evt_flags = flags_q;
    assign irq       = |(flags_q & int_en);
endmodule

// File: rtl/slowtick_rtc_chk.sv
module slowtick_rtc_chk #(
    parameter int unsigned CNT_W = 24,
    parameter int unsigned NCH   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             task_clear,
    input logic             running,
    input logic [NCH:0]     evt_clr,
    input logic [CNT_W-1:0] counter_value,
    input logic [NCH:0]     evt_flags,
    input logic             irq
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (counter_value == '0 && evt_flags == '0 && !irq));

    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (counter_value != $past(counter_value)) |->
            (counter_value == CNT_W'($past(counter_value) + 1'b1) || counter_value == '0));

    a_r3_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(running) && !$past(task_clear)) |-> (counter_value == $past(counter_value)));

    a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        $past(task_clear) |-> (counter_value == '0));

    a_r5_overflow_from_max: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_flags[NCH]) |->
            ($past(counter_value) == {CNT_W{1'b1}} && counter_value == '0));

    a_r8_clear_no_event: assert property (@(posedge clk) disable iff (rst)
        $past(task_clear) |-> ((evt_flags & ~$past(evt_flags)) == '0));

    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(evt_flags) & ~evt_flags & ~$past(evt_clr)) == '0));
endmodule

bind slowtick_rtc slowtick_rtc_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .task_clear    (task_clear),
    .running       (is_running),
    .evt_clr       (evt_clr),
    .counter_value (counter_value),
    .evt_flags     (evt_flags),
    .irq           (irq)
);

// File: tb/slowtick_rtc_test.sv
module slowtick_rtc_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int NC = 4;
    localparam int PW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          task_start, task_stop, task_clear;
    logic [PW-1:0] prescale;
    logic [NC-1:0] cmp_wr;
    logic [CW-1:0] cmp_wdata;
    logic [NC:0]   evt_en, int_en, evt_clr;
    logic [NC-1:0] wrap_route;
    logic [CW-1:0] counter_value;
    logic [NC:0]   evt_flags;
    logic          irq;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slowtick_rtc #(.CNT_W(CW), .NCH(NC), .PRESC_W(PW)) uut (
        .clk(clk), .rst(rst),
        .task_start(task_start), .task_stop(task_stop), .task_clear(task_clear),
        .prescale(prescale), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .evt_en(evt_en), .int_en(int_en), .evt_clr(evt_clr), .wrap_route(wrap_route),
        .counter_value(counter_value), .evt_flags(evt_flags), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic steps(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic s, input logic p, input logic c);
        task_start = s; task_stop = p; task_clear = c;
        @(negedge clk);
        task_start = 1'b0; task_stop = 1'b0; task_clear = 1'b0;
    endtask

    task automatic wr_cmp(input int ch, input int val);
        cmp_wr = NC'(1 << ch); cmp_wdata = CW'(val);
        @(negedge clk);
        cmp_wr = '0;
    endtask

    task automatic clr_flags(input logic [NC:0] m);
        evt_clr = m;
        @(negedge clk);
        evt_clr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cmpv[NC];
        logic [3:0] expf;
        rst = 1'b1;
        task_start = 0; task_stop = 0; task_clear = 0;
        prescale = '0; cmp_wr = '0; cmp_wdata = '0;
        evt_en = '0; int_en = '0; evt_clr = '0; wrap_route = '0;
        steps(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1 counter", int'(counter_value), 0);
        chk_eq("R1 flags", int'(evt_flags), 0);
        chk_eq("R1 irq", int'(irq), 0);
        steps(10);
        chk_eq("R3 halted after reset", int'(counter_value), 0);

        // R2 divide ratio sweep
        for (int p = 0; p < 4; p++) begin
            prescale = PW'(p);
            pulse(1, 0, 1);
            for (int k = 0; k <= 3 * (p + 1) + 2; k++) begin
                chk_eq("R2 tick spacing", int'(counter_value), k / (p + 1));
                steps(1);
            end
            pulse(0, 1, 0);
        end

        // R3 stop holds, start+stop together stays halted, R4 clear
        prescale = '0;
        pulse(1, 0, 1);
        steps(7);
        pulse(0, 1, 0);
        begin
            int held;
            held = int'(counter_value);
            steps(5);
            chk_eq("R3 stop holds", int'(counter_value), held);
            pulse(1, 1, 0);
            steps(4);
            chk_eq("R3 stop wins over start", int'(counter_value), held);
            pulse(1, 0, 0);
            steps(3);
            chk_eq("R3 start resumes", int'(counter_value), held + 3);
        end
        pulse(0, 0, 1);
        chk_eq("R4 clear zeroes", int'(counter_value), 0);
        steps(2);
        chk_eq("R4 clear keeps running", int'(counter_value), 2);
        pulse(0, 1, 0);

        // R5 overflow
        evt_en = 5'b10000;
        clr_flags('1);
        pulse(1, 0, 1);
        steps(255);
        chk_eq("R5 at max", int'(counter_value), 255);
        chk_eq("R5 no flag before wrap", int'(evt_flags[NC]), 0);
        steps(1);
        chk_eq("R5 wrapped", int'(counter_value), 0);
        chk_eq("R5 overflow flag", int'(evt_flags[NC]), 1);
        pulse(0, 1, 0);
        clr_flags('1);
        chk_eq("R9 clear all flags", int'(evt_flags), 0);

        // R6 compare sweep across channels
        evt_en = '1;
        for (int c = 0; c < NC; c++) begin
            cmpv[c] = 10 + 7 * c;
            wr_cmp(c, cmpv[c]);
        end
        prescale = PW'(1);
        pulse(1, 0, 1);
        for (int k = 0; k <= 70; k++) begin
            for (int c = 0; c < NC; c++) expf[c] = ((k / 2) >= cmpv[c]);
            chk_eq("R6 compare flags", int'(evt_flags[NC-1:0]), int'(expf));
            steps(1);
        end
        pulse(0, 1, 0);
        clr_flags('1);

        // R7 late write to count+1 is missed, count+2 is caught
        prescale = PW'(3);
        pulse(1, 0, 1);
        wr_cmp(0, 1);
        wr_cmp(1, 2);
        steps(11);
        chk_eq("R7 count", int'(counter_value), 3);
        chk_eq("R7 ahead-by-one missed", int'(evt_flags[0]), 0);
        chk_eq("R7 ahead-by-two caught", int'(evt_flags[1]), 1);
        pulse(0, 1, 0);

        // R8 clear with compare at zero
        prescale = '0;
        task_start = 1; task_clear = 1; cmp_wr = 4'b0100; cmp_wdata = '0;
        @(negedge clk);
        task_start = 0; task_clear = 0; cmp_wr = '0;
        steps(5);
        clr_flags('1);
        chk_eq("R9 flags cleared", int'(evt_flags), 0);
        pulse(0, 0, 1);
        chk_eq("R8 counter zero", int'(counter_value), 0);
        chk_eq("R8 no zero match on clear", int'(evt_flags[2]), 0);
        steps(1);
        chk_eq("R8 still no zero match", int'(evt_flags[2]), 0);
        pulse(0, 1, 0);

        // R9 gating and selective clear
        evt_en = 5'b10111;
        clr_flags('1);
        pulse(1, 0, 1);
        steps(40);
        pulse(0, 1, 0);
        chk_eq("R9 gated channel not recorded", int'(evt_flags), 5'b00011);
        clr_flags(5'b00001);
        chk_eq("R9 selective clear", int'(evt_flags), 5'b00010);

        // R10 interrupt
        int_en = '0; #1;
        chk_eq("R10 masked", int'(irq), 0);
        int_en = 5'b00010; #1;
        chk_eq("R10 enabled pending", int'(irq), 1);
        int_en = 5'b11101; #1;
        chk_eq("R10 enabled not pending", int'(irq), 0);
        int_en = 5'b00010;
        @(negedge clk);
        clr_flags(5'b00010);
        chk_eq("R10 cleared drops irq", int'(irq), 0);
        int_en = '0;

        // R11 routed wrap at 9
        evt_en = '1;
        clr_flags('1);
        wr_cmp(3, 9);
        wrap_route = 4'b1000;
        pulse(1, 0, 1);
        for (int k = 0; k <= 35; k++) begin
            chk_eq("R11 wrap period", int'(counter_value), k % 10);
            steps(1);
        end
        pulse(0, 1, 0);
        chk_eq("R11 route channel flag", int'(evt_flags[3]), 1);
        chk_eq("R11 no overflow", int'(evt_flags[NC]), 0);
        chk_eq("R8 no zero match on routed wrap", int'(evt_flags[2]), 0);
        wrap_route = '0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule